// File: doc/BRIEF.md
# Link Packet Framer and Serializer

This block turns request descriptors into link packets and streams them out over a narrow link. A descriptor carries a 6-bit command, a 64-bit address and a payload length in bytes. The block builds the packet as a series of 32-bit words: an optional address-extension word, two control words, and then the payload words. It then cuts each word into bit times whose width is chosen at run time.

Payload words are pulled one at a time from a separate valid/ready stream, exactly when they are needed. The last payload word is filled with zeros up to the word boundary. The link width is captured when a descriptor is accepted and holds for the whole packet. The descriptor port reopens only after the final bit time of the packet has gone out.

Top module: `link_pkt_framer`

## Requirements
- R1: While reset is asserted and directly after it, desc_ready is 1, and lnk_valid, pay_ready and lnk_data are all 0.
- R2: A packet without an extension word starts with two control words. Word A is {2'b00, cmd[5:0], addr[23:0]}, with the command in bits 29:24. Word B is {nbytes[7:0], 8'h00, addr[39:24]}.
- R3: When any of address bits 63:40 is 1, an extension word {2'b00, cmd[5:0], addr[63:40]} is sent before word A. When bits 63:40 are all 0, no extension word is sent.
- R4: After the control words come ceil(nbytes/4) payload words, each taken from pay_data on one pay_valid/pay_ready handshake. Byte i of a word sits in bits 8i+7:8i. In the last word, the bytes at index nbytes mod 4 and above are sent as zero when that value is non-zero. A packet with nbytes = 0 has no payload words.
- R5: width_sel values 0, 1, 2, 3 and 4 select 2, 4, 8, 16 and 32 bits, and values 5 to 7 also select 32 bits. Each word takes 32/width bit times, with the low-order slice first. A slice appears on lnk_data[width-1:0], and the bits of lnk_data above the width are 0.
- R6: lnk_ctl is 1 for every bit time of a control or extension word and 0 for every bit time of a payload word.
- R7: width_sel is sampled only on the descriptor handshake. A change to width_sel while a packet is in flight does not alter that packet.
- R8: desc_ready stays 0 from the handshake until the final bit time has been sent, and it is 1 in the cycle after that bit time. lnk_valid is never 1 while desc_ready is 1.
- R9: While the next payload word is not offered, lnk_valid drops to 0. No word is lost, duplicated or reordered. A word, once started, is sent without a gap.
- R10: The cycle right after the descriptor handshake carries no bit time. The first bit time is on the link in the second cycle after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| width_sel | input | 3 | Link width code, sampled at descriptor handshake |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block is idle and accepts a descriptor |
| desc_cmd | input | 6 | Command code |
| desc_addr | input | 64 | Request address |
| desc_nbytes | input | NB_W | Payload length in bytes |
| pay_valid | input | 1 | Payload word offered |
| pay_ready | output | 1 | Payload word taken at this edge when pay_valid is 1 |
| pay_data | input | 32 | Payload word, byte 0 in bits 7:0 |
| lnk_valid | output | 1 | A bit time is on the link |
| lnk_ctl | output | 1 | Current bit time belongs to a control word |
| lnk_data | output | 32 | Link slice in the low width bits, zero above |

## Verification
Two things can fall on the same clock edge: the last bit time of one word goes out, and the next payload word is fetched and loaded. Both happen at the word boundary. The bench provokes this in two ways. It holds pay_valid high so that words follow back to back, and it toggles pay_valid every third cycle so that some boundaries stall and others do not. Each packet is rebuilt from the link slices at every width and compared word by word with values computed from the descriptor. The bench also counts payload handshakes, which exposes any lost, doubled or truncated word. A width change made during the first bit time of a packet checks that the latched width is the one that counts.

// File: rtl/link_pkt_framer.sv
module link_pkt_framer #(
  parameter int NB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      width_sel,
  input  logic            desc_valid,
  output logic            desc_ready,
  input  logic [5:0]      desc_cmd,
  input  logic [63:0]     desc_addr,
  input  logic [NB_W-1:0] desc_nbytes,
  input  logic            pay_valid,
  output logic            pay_ready,
  input  logic [31:0]     pay_data,
  output logic            lnk_valid,
  output logic            lnk_ctl,
  output logic [31:0]     lnk_data
);
  localparam int IDX_W = NB_W + 1;

  logic            busy, full, wctl, wlast;
  logic [2:0]      lsel;
  logic [5:0]      cmd_q;
  logic [63:0]     addr_q;
  logic [NB_W-1:0] nb_q;
  logic [IDX_W-1:0] widx;
  logic [3:0]      beat;
  logic [31:0]     wrd, nxt;

  wire             ext      = |addr_q[63:40];
  wire [IDX_W-1:0] nctl     = ext ? IDX_W'(3) : IDX_W'(2);
  wire [IDX_W-1:0] nwp      = IDX_W'(({1'b0, nb_q} + (NB_W+1)'(3)) >> 2);
  wire [IDX_W-1:0] total    = nctl + nwp;
  wire [IDX_W-1:0] pidx     = widx - nctl;
  wire [IDX_W-1:0] cidx     = ext ? widx : widx + IDX_W'(1);
  wire             is_pay   = widx >= nctl;
  wire [3:0]       last_beat = 4'hF >> lsel;
  wire             beat_end = beat == last_beat;
  wire             more     = widx < total;
  wire             can_load = busy && more && (!full || beat_end);
  wire             load     = can_load && (!is_pay || pay_valid);
  wire [1:0]       tail     = 2'(nb_q);

  assign desc_ready = !busy;
  assign pay_ready  = can_load && is_pay;

  always_comb begin
    nxt = pay_data;
    if (!is_pay) begin
      if (cidx == '0)             nxt = {2'b00, cmd_q, addr_q[63:40]};
      else if (cidx == IDX_W'(1)) nxt = {2'b00, cmd_q, addr_q[23:0]};
      else                        nxt = {8'(nb_q), 8'h00, addr_q[39:24]};
    end else if (pidx == nwp - IDX_W'(1) && tail != 2'd0) begin
      for (int b = 0; b < 4; b++)
        if (b >= int'(tail)) nxt[8*b +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; full <= 1'b0; wctl <= 1'b0; wlast <= 1'b0;
      lsel <= 3'd0; cmd_q <= '0; addr_q <= '0; nb_q <= '0;
      widx <= '0; beat <= '0; wrd <= '0;
    end else begin
      if (desc_valid && !busy) begin
        busy   <= 1'b1;
        widx   <= '0;
        cmd_q  <= desc_cmd;
        addr_q <= desc_addr;
        nb_q   <= desc_nbytes;
        lsel   <= (width_sel > 3'd4) ? 3'd4 : width_sel;
      end
      if (load) begin
        wrd   <= nxt;
        wctl  <= !is_pay;
        wlast <= widx == total - IDX_W'(1);
        full  <= 1'b1;
        beat  <= '0;
        widx  <= widx + IDX_W'(1);
      end else if (full) begin
        if (beat_end) begin
          full <= 1'b0;
          beat <= '0;
          if (wlast) busy <= 1'b0;
        end else begin
          beat <= beat + 4'd1;
        end
      end
    end
  end

  wire [4:0]  sh    = 5'({beat, 1'b0} << lsel);
  wire [5:0]  wbits = 6'd2 << lsel;
  wire [31:0] wmask = 32'hFFFF_FFFF >> (6'd32 - wbits);

  assign lnk_valid = full;
  assign lnk_ctl   = full & wctl;
  assign lnk_data  = full ? ((wrd >> sh) & wmask) : 32'h0;

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !lnk_valid);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid && beat_end && wlast |=> desc_ready);
  p_width_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(lsel));
  p_ctl_leads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid && !lnk_ctl |=> !lnk_ctl);
  p_no_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_valid && !beat_end |=> lnk_valid);
endmodule

// File: tb/sim_link_pkt_framer.sv
module sim_link_pkt_framer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [2:0]  width_sel;
  logic        desc_valid, desc_ready;
  logic [5:0]  desc_cmd;
  logic [63:0] desc_addr;
  logic [7:0]  desc_nbytes;
  logic        pay_valid, pay_ready;
  logic [31:0] pay_data;
  logic        lnk_valid, lnk_ctl;
  logic [31:0] lnk_data;

  link_pkt_framer #(.NB_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_cmd(desc_cmd), .desc_addr(desc_addr), .desc_nbytes(desc_nbytes),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .lnk_valid(lnk_valid), .lnk_ctl(lnk_ctl), .lnk_data(lnk_data)
  );

  int total_n = 0, bad_n = 0;
  bit done = 1'b0;

  // {sel[2:0], cmd[5:0], addr[63:0], nbytes[7:0], width_change, stall}
  localparam logic [82:0] VEC [8] = '{
    {3'd0, 6'h05, 64'h0000_0012_3456_789A, 8'd0,   1'b0, 1'b0},
    {3'd4, 6'h2A, 64'h0000_00FF_FFFF_FFFC, 8'd4,   1'b0, 1'b0},
    {3'd2, 6'h11, 64'h0000_0100_0000_0040, 8'd5,   1'b0, 1'b0},
    {3'd1, 6'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 8'd7,   1'b0, 1'b0},
    {3'd3, 6'h00, 64'h8000_0000_0000_0000, 8'd255, 1'b0, 1'b0},
    {3'd7, 6'h21, 64'h0000_0000_0000_1000, 8'd6,   1'b0, 1'b0},
    {3'd2, 6'h0C, 64'h00AB_0000_0000_0000, 8'd9,   1'b1, 1'b1},
    {3'd0, 6'h1D, 64'h0000_0080_0000_0000, 8'd3,   1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pw(input int pk, input int k);
    return 32'(32'h9E37_79B9 * (k + 1)) ^ 32'(pk << 20);
  endfunction

  function automatic logic [32:0] expw(input logic [5:0] c, input logic [63:0] a,
                                       input logic [7:0] nb, input int pk, input int i);
    bit ext;
    int j, p, nwd, t;
    logic [31:0] w;
    ext = a[63:40] != 24'h0;
    j = ext ? i : i + 1;
    if (j == 0) return {1'b1, 2'b00, c, a[63:40]};
    if (j == 1) return {1'b1, 2'b00, c, a[23:0]};
    if (j == 2) return {1'b1, nb, 8'h00, a[39:24]};
    p = j - 3;
    nwd = (int'(nb) + 3) / 4;
    t = int'(nb) % 4;
    w = pw(pk, p);
    if (p == nwd - 1 && t != 0)
      for (int b = 0; b < 4; b++) if (b >= t) w[8*b +: 8] = 8'h00;
    return {1'b0, w};
  endfunction

  task automatic run_pkt(input int pk, input logic [2:0] sel, input logic [5:0] cmd,
                         input logic [63:0] addr, input logic [7:0] nb,
                         input bit chg, input bit stall);
    int w, bpw, nw, got, beat, k, cyc, first;
    bit hs, up_ok, ctl_ok, rdy_ok, cf, ext;
    logic [31:0] acc, m;
    logic [32:0] e;
    string tag;
    w = (sel > 3'd4) ? 32 : (2 << sel);
    bpw = 32 / w;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    ext = addr[63:40] != 24'h0;
    nw = (ext ? 3 : 2) + (int'(nb) + 3) / 4;
    got = 0; beat = 0; k = 0; cyc = 0; first = -1;
    up_ok = 1; ctl_ok = 1; rdy_ok = 1; cf = 0; acc = '0;
    tag = $sformatf("R5%s%s", chg ? " R7" : "", stall ? " R9" : "");
    @(negedge clk);
    chk(desc_ready === 1'b1, "R8", "ready before packet", 64'(desc_ready), 64'd1);
    width_sel = sel; desc_cmd = cmd; desc_addr = addr; desc_nbytes = nb;
    pay_data = pw(pk, 0); pay_valid = 1'b1; desc_valid = 1'b1;
    @(posedge clk); #1;
    desc_valid = 1'b0;
    while (got < nw && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      hs = pay_ready && pay_valid;
      if (desc_ready) rdy_ok = 0;
      if (lnk_valid) begin
        if (first < 0) first = cyc;
        if (got == 0 && beat == 0 && chg) width_sel = (sel == 3'd0) ? 3'd3 : 3'd0;
        if ((lnk_data & ~m) != 32'h0) up_ok = 0;
        acc = acc | ((lnk_data & m) << (beat * w));
        if (beat == 0) cf = lnk_ctl;
        else if (lnk_ctl != cf) ctl_ok = 0;
        beat++;
        if (beat == bpw) begin
          e = expw(cmd, addr, nb, pk, got);
          if (e[32])
            chk(acc == e[31:0] && cf, (ext && got == 0) ? $sformatf("R3 R6 %s", tag) : $sformatf("R2 R6 %s", tag),
                $sformatf("pkt%0d ctl word %0d", pk, got), {31'h0, cf, acc}, {31'h0, 1'b1, e[31:0]});
          else
            chk(acc == e[31:0] && !cf, $sformatf("R4 R6 %s", tag),
                $sformatf("pkt%0d payload word %0d", pk, got), {31'h0, cf, acc}, {32'h0, e[31:0]});
          got++; beat = 0; acc = '0;
        end
      end
      @(posedge clk); #1;
      if (hs) begin k++; pay_data = pw(pk, k); end
      if (stall) pay_valid = (cyc % 3) != 1;
    end
    chk(got == nw, "R9", $sformatf("pkt%0d word count", pk), 64'(got), 64'(nw));
    chk(k == (int'(nb) + 3) / 4, "R4", $sformatf("pkt%0d payload handshakes", pk), 64'(k), 64'((int'(nb) + 3) / 4));
    chk(first == 2, "R10", $sformatf("pkt%0d first bit time cycle", pk), 64'(first), 64'd2);
    chk(up_ok, "R5", $sformatf("pkt%0d bits above width zero", pk), 64'(up_ok), 64'd1);
    chk(ctl_ok, "R6", $sformatf("pkt%0d flag steady in word", pk), 64'(ctl_ok), 64'd1);
    chk(rdy_ok, "R8", $sformatf("pkt%0d ready low in flight", pk), 64'(rdy_ok), 64'd1);
    @(negedge clk);
    chk(desc_ready === 1'b1 && lnk_valid === 1'b0, "R8", $sformatf("pkt%0d released", pk),
        {62'h0, desc_ready, lnk_valid}, 64'h2);
    pay_valid = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total_n++; bad_n++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end

  initial begin
    logic [82:0] v;
    rst_n = 1'b0; width_sel = 3'd0; desc_valid = 1'b0; desc_cmd = '0;
    desc_addr = '0; desc_nbytes = '0; pay_valid = 1'b0; pay_data = '0;
    repeat (3) @(negedge clk);
    chk(desc_ready === 1'b1 && lnk_valid === 1'b0 && pay_ready === 1'b0 && lnk_data === 32'h0,
        "R1", "in reset", {desc_ready, lnk_valid, pay_ready, lnk_data}, {3'b100, 32'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_ready === 1'b1 && lnk_valid === 1'b0 && pay_ready === 1'b0,
        "R1", "after reset", {desc_ready, lnk_valid, pay_ready}, 3'b100);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      run_pkt(i, v[82:80], v[79:74], v[73:10], v[9:2], v[1], v[0]);
    end

    // R1: reset in the middle of a packet
    @(negedge clk);
    width_sel = 3'd0; desc_cmd = 6'h07; desc_addr = 64'h0000_0400_0000_0000;
    desc_nbytes = 8'd20; pay_valid = 1'b1; pay_data = 32'h1234_5678; desc_valid = 1'b1;
    @(posedge clk); #1;
    desc_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(lnk_valid === 1'b1, "R1", "packet in flight before reset", 64'(lnk_valid), 64'd1);
    rst_n = 1'b0;
    #1;
    chk(desc_ready === 1'b1 && lnk_valid === 1'b0 && pay_ready === 1'b0 && lnk_data === 32'h0,
        "R1", "reset mid packet", {desc_ready, lnk_valid, pay_ready, lnk_data}, {3'b100, 32'h0});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lnk_valid === 1'b0 && desc_ready === 1'b1, "R1", "quiet after reset",
        {desc_ready, lnk_valid}, 2'b10);

    // R3: address bit 40 alone forces the extension word after reset
    run_pkt(9, 3'd4, 6'h33, 64'h0000_0100_0000_0000, 8'd1, 1'b0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule